// File: doc/BRIEF.md
# Fixed-Point Requantizer with Selectable Rounding

This block narrows a fixed-point sample. It takes a word in Qa.b format and returns a word in Qc.d format, with d smaller than b. The binary point is never carried in the data. The four parameters `IN_INT`, `IN_FRAC`, `OUT_INT` and `OUT_FRAC` place it, and the integer counts include the sign bit. A further parameter picks signed (two's-complement) or unsigned interpretation.

The low `IN_FRAC-OUT_FRAC` bits are dropped. A per-sample mode input then decides whether one unit of the new LSB is added back:

- floor: nothing is added.
- ceiling: one is added when any dropped bit is set.
- round-half-up: one is added when the top dropped bit is set.
- round-half-to-even: the same as round-half-up, except that on an exact tie one is added only when the kept LSB is 1.

The decision uses only bit tests on the dropped bits. The result is then resized to the output integer width. If it does not fit, it is clamped to the nearest representable extreme and an overflow flag is raised for that sample.

A parameter selects one of two forms. In the registered form, a single output register adds exactly one cycle of latency, and the input valid travels with the data. In the combinational form, the block is pure logic.

Top module: `rq_requantizer`

## Requirements
- R1: While reset is low, and on the first cycle after it rises, `out_valid`, `out_data` and `out_ovf` are all 0.
- R2: Mode 2'b00 (floor) returns the largest representable output not above the input value. For signed data, this rounds negative values toward minus infinity.
- R3: Mode 2'b01 (ceiling) returns floor plus one output LSB when any dropped fraction bit is 1, and floor otherwise.
- R4: Mode 2'b10 (round-half-up) returns floor plus one output LSB when the most significant dropped bit is 1, and floor otherwise.
- R5: Mode 2'b11 (round-half-to-even) adds one when the dropped bits exceed one half. On an exact half (top dropped bit 1, the rest 0), it adds one only if the kept LSB is 1. Otherwise it returns floor.
- R6: A rounded result above the output maximum, or below the output minimum, is replaced by that extreme, and `out_ovf` is 1 for that sample. For signed data the extremes are 0 followed by all ones, and 1 followed by all zeros. For unsigned data they are all ones and zero.
- R7: In the registered form, `out_valid` equals `in_valid` one cycle later. `out_data` and `out_ovf` take a new value only for a valid input, and hold otherwise.
- R8: When every dropped bit is 0, all four modes return the input value unchanged, apart from the resize of R6. This covers sign extension (or zero extension) when the output integer part is wider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample is valid |
| in_data | input | IN_INT+IN_FRAC | Input word, Q(IN_INT).(IN_FRAC) |
| mode | input | 2 | Rounding mode: 00 floor, 01 ceiling, 10 half-up, 11 half-to-even |
| out_valid | output | 1 | Output sample is valid |
| out_data | output | OUT_INT+OUT_FRAC | Result word, Q(OUT_INT).(OUT_FRAC) |
| out_ovf | output | 1 | Result was clamped |

## Verification
The assertions assume the following about the inputs:

- The registered form is in use.
- `in_data` and `mode` are stable, known values whenever `in_valid` is high.

The bench drives every input word in each of the four modes. It keeps `mode` constant for a whole sweep and changes inputs only at the falling edge. It drops `in_valid` at a fixed stride, which exercises the hold behaviour without breaking those assumptions.

The reference model uses plain integer division by a power of two. That makes ties, negative values and both saturation ends fall out of the sweep rather than needing hand-picked vectors.

// File: rtl/rq_pkg.sv
// Shared types for the requantizer: the rounding-mode encoding.
package rq_pkg;
    typedef enum logic [1:0] {
        RQ_FLOOR      = 2'b00,
        RQ_CEIL       = 2'b01,
        RQ_HALF_UP    = 2'b10,
        RQ_HALF_EVEN  = 2'b11
    } rq_mode_e;
endpackage

// File: rtl/rq_round_inc.sv
// Increment decision: decides whether one output LSB is added back after
// the low DROP bits are removed. Assumes DROP >= 1.
module rq_round_inc
    import rq_pkg::*;
#(
    parameter int DROP = 4
) (
    input  logic [DROP-1:0] disc,
    input  logic            kept_lsb,
    input  rq_mode_e        mode,
    output logic            inc
);
    logic half_bit;
    logic below_half;

    generate
        if (DROP == 1) begin : g_single
            assign half_bit   = disc[0];
            assign below_half = 1'b0;
        end else begin : g_multi
            assign half_bit   = disc[DROP-1];
            assign below_half = |disc[DROP-2:0];
        end
    endgenerate

    // Select the increment from the mode and the dropped-bit tests.
    always_comb begin
        case (mode)
            RQ_FLOOR:     inc = 1'b0;
            RQ_CEIL:      inc = half_bit | below_half;
            RQ_HALF_UP:   inc = half_bit;
            RQ_HALF_EVEN: inc = half_bit & (below_half | kept_lsb);
            default:      inc = 1'b0;
        endcase
    end
endmodule

// File: rtl/rq_resize_sat.sv
// Resize and clamp: fits a wide signed sum into OUT_W bits. Values beyond
// the representable range become the nearest extreme and raise ovf.
// Assumes SUM_W > OUT_W, so that the sum is never itself truncated.
module rq_resize_sat #(
    parameter int SUM_W  = 8,
    parameter int OUT_W  = 5,
    parameter bit SIGNED = 1'b1
) (
    input  logic signed [SUM_W-1:0] sum,
    output logic        [OUT_W-1:0] res,
    output logic                    ovf
);
    localparam longint MAX_L = SIGNED ? (longint'(1) <<< (OUT_W-1)) - 1
                                      : (longint'(1) <<< OUT_W) - 1;
    localparam longint MIN_L = SIGNED ? -(longint'(1) <<< (OUT_W-1)) : 0;
    localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'(MAX_L);
    localparam logic signed [SUM_W-1:0] MIN_V = SUM_W'(MIN_L);

    logic hi, lo;

    // Compare against the range and pick the clamped or the plain value.
    always_comb begin
        hi  = sum > MAX_V;
        lo  = sum < MIN_V;
        ovf = hi | lo;
        if (hi)      res = MAX_V[OUT_W-1:0];
        else if (lo) res = MIN_V[OUT_W-1:0];
        else         res = sum[OUT_W-1:0];
    end
endmodule

// File: rtl/rq_requantizer.sv
// Top: requantizes Q(IN_INT).(IN_FRAC) to Q(OUT_INT).(OUT_FRAC) under a
// per-sample rounding mode. Assumes OUT_FRAC < IN_FRAC and that
// IN_INT + OUT_FRAC >= 1. REGISTERED selects one register stage or none.
module rq_requantizer
    import rq_pkg::*;
#(
    parameter int IN_INT     = 4,
    parameter int IN_FRAC    = 6,
    parameter int OUT_INT    = 3,
    parameter int OUT_FRAC   = 2,
    parameter bit SIGNED     = 1'b1,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [IN_INT+IN_FRAC-1:0]    in_data,
    input  logic [1:0]                   mode,
    output logic                         out_valid,
    output logic [OUT_INT+OUT_FRAC-1:0]  out_data,
    output logic                         out_ovf
);
    localparam int IN_W  = IN_INT + IN_FRAC;
    localparam int OUT_W = OUT_INT + OUT_FRAC;
    localparam int DROP  = IN_FRAC - OUT_FRAC;
    localparam int KW    = IN_W - DROP;
    localparam int SUM_W = ((KW > OUT_W) ? KW : OUT_W) + 2;

    logic [KW-1:0]           kept;
    logic [DROP-1:0]         disc;
    logic                    inc;
    logic signed [SUM_W-1:0] kept_ext;
    logic signed [SUM_W-1:0] sum;
    logic [OUT_W-1:0]        res_c;
    logic                    ovf_c;

    assign kept = in_data[IN_W-1:DROP];
    assign disc = in_data[DROP-1:0];

    generate
        if (SIGNED) begin : g_sext
            assign kept_ext = {{(SUM_W-KW){kept[KW-1]}}, kept};
        end else begin : g_zext
            assign kept_ext = {{(SUM_W-KW){1'b0}}, kept};
        end
    endgenerate

    rq_round_inc #(.DROP(DROP)) u_inc (
        .disc     (disc),
        .kept_lsb (kept[0]),
        .mode     (rq_mode_e'(mode)),
        .inc      (inc)
    );

    assign sum = kept_ext + {{(SUM_W-1){1'b0}}, inc};

    rq_resize_sat #(.SUM_W(SUM_W), .OUT_W(OUT_W), .SIGNED(SIGNED)) u_sat (
        .sum (sum),
        .res (res_c),
        .ovf (ovf_c)
    );

    generate
        if (REGISTERED) begin : g_reg
            // Output stage: capture the result for valid samples.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid <= 1'b0;
                    out_data  <= '0;
                    out_ovf   <= 1'b0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) begin
                        out_data <= res_c;
                        out_ovf  <= ovf_c;
                    end
                end
            end
        end else begin : g_comb
            assign out_valid = in_valid;
            assign out_data  = res_c;
            assign out_ovf   = ovf_c;
        end
    endgenerate
endmodule

// File: rtl/rq_requantizer_chk.sv
// Checker for the registered form of rq_requantizer, attached by bind.
// Assumes in_data and mode are known whenever in_valid is high.
module rq_requantizer_chk #(
    parameter int IN_INT     = 4,
    parameter int IN_FRAC    = 6,
    parameter int OUT_INT    = 3,
    parameter int OUT_FRAC   = 2,
    parameter bit SIGNED     = 1'b1,
    parameter bit REGISTERED = 1'b1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic [IN_INT+IN_FRAC-1:0]   in_data,
    input logic [1:0]                  mode,
    input logic                        out_valid,
    input logic [OUT_INT+OUT_FRAC-1:0] out_data,
    input logic                        out_ovf
);
    localparam int OUT_W = OUT_INT + OUT_FRAC;
    localparam int DROP  = IN_FRAC - OUT_FRAC;
    localparam logic [DROP-1:0]  TIE   = DROP'(1) << (DROP-1);
    localparam logic [OUT_W-1:0] MAX_O = SIGNED ? {1'b0, {(OUT_W-1){1'b1}}} : {OUT_W{1'b1}};
    localparam logic [OUT_W-1:0] MIN_O = SIGNED ? {1'b1, {(OUT_W-1){1'b0}}} : {OUT_W{1'b0}};

    generate
        if (REGISTERED) begin : g_chk
            // R1
            reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> !out_valid);
            // R7
            valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            // R7
            valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            // R6
            ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && out_ovf) |-> (out_data == MAX_O || out_data == MIN_O));
            // R2
            floor_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && mode == 2'b00) |=> (out_ovf || out_data[0] == $past(in_data[DROP])));
            // R4
            half_up_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && mode == 2'b10 && !in_data[DROP-1])
                |=> (out_ovf || out_data[0] == $past(in_data[DROP])));
            // R5
            even_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && mode == 2'b11 && in_data[DROP-1:0] == TIE)
                |=> (out_ovf || !out_data[0]));
            // R8
            exact_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_data[DROP-1:0] == '0)
                |=> (out_ovf || out_data[0] == $past(in_data[DROP])));
        end
    endgenerate
endmodule

bind rq_requantizer rq_requantizer_chk #(
    .IN_INT(IN_INT), .IN_FRAC(IN_FRAC), .OUT_INT(OUT_INT),
    .OUT_FRAC(OUT_FRAC), .SIGNED(SIGNED), .REGISTERED(REGISTERED)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .mode(mode), .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf)
);

// File: tb/tb_rq_requantizer.sv
module tb_rq_requantizer;
    localparam int IN_INT = 4, IN_FRAC = 6, OUT_INT = 3, OUT_FRAC = 2;
    localparam bit SIGNED = 1'b1;
    localparam int IN_W  = IN_INT + IN_FRAC;
    localparam int OUT_W = OUT_INT + OUT_FRAC;
    localparam int DROP  = IN_FRAC - OUT_FRAC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [IN_W-1:0] in_data = '0;
    logic [1:0] mode = 2'b00;
    logic out_valid;
    logic [OUT_W-1:0] out_data;
    logic out_ovf;

    int n_tests = 0;
    int n_fail  = 0;

    // Expected outputs for the next sampling point.
    bit              exp_valid = 1'b0;
    logic [OUT_W-1:0] exp_data = '0;
    bit              exp_ovf   = 1'b0;
    string           exp_tag   = "R1";

    always #4 clk = ~clk;

    rq_requantizer #(
        .IN_INT(IN_INT), .IN_FRAC(IN_FRAC), .OUT_INT(OUT_INT),
        .OUT_FRAC(OUT_FRAC), .SIGNED(SIGNED), .REGISTERED(1'b1)
    ) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .mode(mode), .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf)
    );

    // Reference: integer division by 2^DROP, then the mode rule and a clamp.
    function automatic void ref_q(input int v, input int m, output int r, output bit ov, output bit exact);
        int fl, rem, half, q, maxv, minv;
        fl    = v >>> DROP;
        rem   = v - fl * (1 << DROP);
        half  = 1 << (DROP - 1);
        exact = (rem == 0);
        case (m)
            0: q = fl;
            1: q = fl + ((rem != 0) ? 1 : 0);
            2: q = fl + ((rem >= half) ? 1 : 0);
            default: q = (rem > half) ? fl + 1 : (rem == half) ? fl + (fl & 1) : fl;
        endcase
        maxv = SIGNED ? (1 << (OUT_W - 1)) - 1 : (1 << OUT_W) - 1;
        minv = SIGNED ? -(1 << (OUT_W - 1)) : 0;
        ov = (q > maxv) || (q < minv);
        r  = (q > maxv) ? maxv : (q < minv) ? minv : q;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv, input string what);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // One cycle: check the last expectation, then apply new inputs.
    task automatic step(input logic [IN_W-1:0] d, input bit v, input logic [1:0] m);
        int r, val;
        bit ov, ex;
        @(negedge clk);
        check("R7", 32'(out_valid), 32'(exp_valid), "out_valid");
        check(exp_tag, 32'(out_data), 32'(exp_data), "out_data");
        check(exp_ovf ? "R6" : exp_tag, 32'(out_ovf), 32'(exp_ovf), "out_ovf");
        in_data  = d;
        in_valid = v;
        mode     = m;
        exp_valid = v;
        if (v) begin
            val = SIGNED ? int'($signed(d)) : int'({1'b0, d});
            ref_q(val, int'(m), r, ov, ex);
            exp_data = r[OUT_W-1:0];
            exp_ovf  = ov;
            if (ov)      exp_tag = "R6";
            else if (ex) exp_tag = "R8";
            else case (m)
                2'b00: exp_tag = "R2";
                2'b01: exp_tag = "R3";
                2'b10: exp_tag = "R4";
                default: exp_tag = "R5";
            endcase
        end else begin
            exp_tag = "R7";
        end
    endtask

    initial begin : watchdog
        #(200000 * 8);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs idle during reset
        check("R1", 32'(out_valid), 32'd0, "out_valid in reset");
        check("R1", 32'(out_data), 32'd0, "out_data in reset");
        check("R1", 32'(out_ovf), 32'd0, "out_ovf in reset");
        rst_n = 1'b1;
        // R1: first cycle after reset remains idle (checked by first step)
        for (int m = 0; m < 4; m++) begin
            for (int x = 0; x < (1 << IN_W); x++) begin
                step(IN_W'(x), (x % 7) != 3, 2'(m));
            end
        end
        // Directed ties and extremes for R5, R4, R6 (Q4.6 -> Q3.2).
        step(10'b0000_011000, 1'b1, 2'b11); // 0.375 -> tie, kept odd -> 0.5
        step(10'b0000_101000, 1'b1, 2'b11); // 0.625 -> tie, kept even -> 0.5
        step(10'b1111_111000, 1'b1, 2'b10); // -0.125 -> 0
        step(10'b0111_111111, 1'b1, 2'b01); // max input, ceiling -> clamp
        step(10'b1000_000000, 1'b1, 2'b00); // min input -> clamp
        step('0, 1'b0, 2'b00);
        step('0, 1'b0, 2'b00);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule